// File: doc/BRIEF.md
# Boot ROM Overlay and CPU Clock-Rate Controller

This controller decides, for every CPU bus cycle, whether the access goes to a small boot ROM or to main RAM, and how often the CPU is allowed to advance. After reset it is in boot mode. In boot mode the CPU steps slowly, once every `DIV` fast clock cycles, so that a slow ROM can keep up. Reads that fall in the topmost `ROM_BYTES` of the address space return ROM data. Every other access goes to RAM, and this includes all writes, even writes into the ROM window. Boot firmware can therefore copy itself into the RAM underneath the ROM by reading each location and writing it back to the same address.

When the CPU makes any access, read or write, to a chosen low address, boot mode ends on that CPU cycle. From the next fast clock cycle on, the CPU advances on every fast cycle and ROM is never selected again. Reads of the top window then return the RAM copy. Only a reset brings boot mode back.

The CPU is paced by a clock enable. The design never gates a clock. A CPU bus cycle ends on a fast-clock cycle in which `cpu_ce` is high. The address and direction present in that cycle form the access.

Top module: `boot_overlay_ctrl`

## Requirements
- R1: While reset is asserted `cpu_ce` is 0. After reset is released and while boot mode is active, `cpu_ce` is high for exactly one fast cycle in every `DIV` cycles. The first pulse comes in the `DIV`-th cycle after release.
- R2: In boot mode, a read (`rd_wr`=1) with address at or above `2**ADDR_W - ROM_BYTES` (0xF800 by default) gives `rom_sel`=1 and `ram_sel`=0.
- R3: In boot mode, a read below the top window gives `ram_sel`=1 and `rom_sel`=0.
- R4: A write (`rd_wr`=0) gives `ram_sel`=1 and `rom_sel`=0 at any address and in either mode.
- R5: In every cycle exactly one of `rom_sel` and `ram_sel` is 1.
- R6: Boot mode ends on a cycle with `cpu_ce`=1 whose address equals `TRIG_ADDR`, for a read or a write. The trigger address seen in a cycle with `cpu_ce`=0 has no effect.
- R7: Once boot mode has ended, `cpu_ce` is 1 in every cycle.
- R8: Once boot mode has ended, reads of the top window give `ram_sel`=1, and `rom_sel` stays 0.
- R9: Further accesses to `TRIG_ADDR` after boot mode has ended do not bring it back. Only reset re-enters boot mode.
- R10: The rate changes only at a CPU cycle boundary. In boot mode, a `cpu_ce` pulse that is not a trigger access is followed by a cycle with `cpu_ce`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset; enters boot mode |
| addr | input | ADDR_W | CPU address of the current bus cycle |
| rd_wr | input | 1 | 1 = read, 0 = write |
| rom_sel | output | 1 | Selects the boot ROM for this access |
| ram_sel | output | 1 | Selects RAM for this access |
| cpu_ce | output | 1 | CPU clock enable; high in the last fast cycle of a CPU cycle |

## Verification
The assertions assume that `addr` and `rd_wr` are settled before the fast clock edge in each cycle, and that an access is counted only in a cycle where `cpu_ce` is high. The bench drives both inputs half a period away from the rising edge, holding them steady across it. It places the trigger address in cycles both with and without the enable pulse, so that only a real access ends boot mode. It also requires `DIV` to be at least 2, so a slow pulse can be told apart from full speed.

// File: rtl/boot_overlay_pkg.sv
package boot_overlay_pkg;
  typedef enum logic {
    MODE_BOOT_SLOW = 1'b0,
    MODE_RUN_FAST  = 1'b1
  } speed_mode_e;
endpackage

// File: rtl/boot_ce_gen.sv
module boot_ce_gen
  import boot_overlay_pkg::*;
#(
  parameter int unsigned DIV = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  speed_mode_e mode,
  output logic        ce
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  generate
    if (DIV <= 1) begin : g_nodiv
      assign ce = rst_n;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      logic          slow_hit;

      assign slow_hit = (cnt_q == LAST);

      always_comb begin
        if (!rst_n)                     ce = 1'b0;
        else if (mode == MODE_RUN_FAST) ce = 1'b1;
        else                            ce = slow_hit;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (mode == MODE_RUN_FAST) cnt_q <= '0;
        else if (slow_hit)              cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/boot_mode_fsm.sv
module boot_mode_fsm
  import boot_overlay_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned TRIG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce,
  output speed_mode_e       mode
);
  localparam logic [ADDR_W-1:0] TRIG = ADDR_W'(TRIG_ADDR);

  speed_mode_e mode_q, mode_d;
  logic        trig_access;

  assign trig_access = ce && (addr == TRIG);

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      MODE_BOOT_SLOW: if (trig_access) mode_d = MODE_RUN_FAST;
      MODE_RUN_FAST:  mode_d = MODE_RUN_FAST;
      default:        mode_d = MODE_BOOT_SLOW;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_BOOT_SLOW;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/boot_addr_decode.sv
module boot_addr_decode
  import boot_overlay_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned ROM_BYTES = 2048
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_wr,
  input  speed_mode_e       mode,
  output logic              rom_sel,
  output logic              ram_sel
);
  localparam int unsigned ROM_AW = $clog2(ROM_BYTES);

  logic in_top;
  logic booting;

  assign in_top  = &addr[ADDR_W-1:ROM_AW];
  assign booting = (mode == MODE_BOOT_SLOW);

  assign rom_sel = booting && rd_wr && in_top;
  assign ram_sel = !rd_wr || !in_top || !booting;
endmodule

// File: rtl/boot_overlay_ctrl.sv
module boot_overlay_ctrl
  import boot_overlay_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned ROM_BYTES = 2048,
  parameter int unsigned DIV       = 16,
  parameter int unsigned TRIG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_wr,
  output logic              rom_sel,
  output logic              ram_sel,
  output logic              cpu_ce
);
  speed_mode_e mode;

  boot_ce_gen #(.DIV(DIV)) u_ce (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode),
    .ce    (cpu_ce)
  );

  boot_mode_fsm #(.ADDR_W(ADDR_W), .TRIG_ADDR(TRIG_ADDR)) u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .ce    (cpu_ce),
    .mode  (mode)
  );

  boot_addr_decode #(.ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES)) u_dec (
    .addr    (addr),
    .rd_wr   (rd_wr),
    .mode    (mode),
    .rom_sel (rom_sel),
    .ram_sel (ram_sel)
  );
endmodule

// File: rtl/boot_overlay_checker.sv
module boot_overlay_checker #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned ROM_BYTES = 2048,
  parameter int unsigned DIV       = 16,
  parameter int unsigned TRIG_ADDR = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_wr,
  input logic              rom_sel,
  input logic              ram_sel,
  input logic              cpu_ce
);
  localparam int unsigned ROM_AW = $clog2(ROM_BYTES);
  localparam int unsigned CW     = (DIV > 1) ? $clog2(DIV) + 1 : 2;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [ADDR_W-1:0] TRIG = ADDR_W'(TRIG_ADDR);

  logic          fast_q;
  logic [CW-1:0] gap_q;
  logic          top;

  assign top = &addr[ADDR_W-1:ROM_AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      if (cpu_ce && addr == TRIG) fast_q <= 1'b1;
      if (cpu_ce) gap_q <= '0;
      else        gap_q <= gap_q + 1'b1;
    end
  end

  p_slow_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_q |-> (cpu_ce == (gap_q == LAST)));
  p_boot_rom_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_q && rd_wr && top) |-> rom_sel);
  p_low_read_ram_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_wr && !top) |-> (ram_sel && !rom_sel));
  p_write_ram_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_wr |-> (ram_sel && !rom_sel));
  p_one_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({rom_sel, ram_sel}));
  p_trigger_ends_boot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce && addr == TRIG) |=> cpu_ce);
  p_fast_every_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fast_q |-> cpu_ce);
  p_no_rom_after_boot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fast_q |-> !rom_sel);
  p_slow_then_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_q && cpu_ce && addr != TRIG) |=> !cpu_ce);
endmodule

bind boot_overlay_ctrl boot_overlay_checker #(
  .ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES), .DIV(DIV), .TRIG_ADDR(TRIG_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_wr(rd_wr),
  .rom_sel(rom_sel), .ram_sel(ram_sel), .cpu_ce(cpu_ce)
);

// File: tb/boot_overlay_ctrl_tb.sv
`timescale 1ns/1ps
module boot_overlay_ctrl_tb;
  localparam int DIV  = 16;
  localparam int TRIG = 0;
  localparam int TOPB = 16'hF800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'hFFFF;
  logic        rd_wr = 1'b1;
  logic        rom_sel, ram_sel, cpu_ce;

  int checks = 0;
  int fails  = 0;
  int m_cnt  = 0;
  bit m_boot = 1'b1;
  bit last_ce_obs;

  always #2.5 clk = ~clk;

  boot_overlay_ctrl #(.ADDR_W(16), .ROM_BYTES(2048), .DIV(DIV), .TRIG_ADDR(TRIG)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_wr(rd_wr),
    .rom_sel(rom_sel), .ram_sel(ram_sel), .cpu_ce(cpu_ce)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare against the behavioural model, then advance the model by one cycle
  task automatic eval();
    bit exp_ce, exp_rom, top;
    string rq_ce, rq_sel;
    #1;
    exp_ce  = m_boot ? (m_cnt == DIV - 1) : 1'b1;
    top     = (int'(addr) >= TOPB);
    exp_rom = m_boot && rd_wr && top;
    rq_ce   = m_boot ? "R1" : "R7";
    if (!rd_wr)      rq_sel = "R4";
    else if (!m_boot) rq_sel = "R8";
    else if (top)    rq_sel = "R2";
    else             rq_sel = "R3";
    check(cpu_ce == exp_ce, rq_ce, "cpu_ce", cpu_ce, exp_ce);
    check(rom_sel == exp_rom, rq_sel, "rom_sel", rom_sel, exp_rom);
    check(ram_sel == !exp_rom, rq_sel, "ram_sel", ram_sel, !exp_rom);
    check((rom_sel ^ ram_sel) == 1'b1, "R5", "one select", rom_sel + ram_sel, 1);
    last_ce_obs = cpu_ce;
    if (m_boot) begin
      if (exp_ce && int'(addr) == TRIG) m_boot = 1'b0;
      m_cnt = exp_ce ? 0 : m_cnt + 1;
    end
  endtask

  task automatic step(input int a, input bit rw);
    @(negedge clk);
    addr  = a[15:0];
    rd_wr = rw;
    eval();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    addr  = 16'hFFFF;
    rd_wr = 1'b1;
    #1;
    check(cpu_ce == 1'b0, "R1", "reset cpu_ce", cpu_ce, 0);
    check(rom_sel == 1'b1, "R2", "reset rom_sel", rom_sel, 1);
    @(negedge clk);
    @(negedge clk);
    rst_n  = 1'b1;
    m_boot = 1'b1;
    m_cnt  = 0;
    eval();
  endtask

  function automatic int pat(input int i);
    int a;
    a = (i * 40503 + 7919) & 16'hFFFF;
    if (i % 4 == 1) a = a | 16'hF800;
    if (a == TRIG) a = 1;
    return a;
  endfunction

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    // boot phase: mixed reads and writes, top and low
    for (int i = 0; i < 48; i++) step(pat(i), (i % 3) != 0);
    // R6: trigger address on a non-enable cycle must not end boot
    while (m_cnt != 3) step(16'h1234, 1'b1);
    step(TRIG, 1'b1);
    check(last_ce_obs == 1'b0, "R6", "trigger without ce", last_ce_obs, 0);
    step(16'hFFF0, 1'b1);
    check(rom_sel == 1'b1, "R6", "still boot after idle trigger", rom_sel, 1);
    // end boot with a read of the trigger
    while (m_boot) step(TRIG, 1'b1);
    check(last_ce_obs == 1'b1, "R10", "switch on ce pulse", last_ce_obs, 1);
    step(16'hFC00, 1'b1);
    check(cpu_ce == 1'b1, "R7", "first fast cycle", cpu_ce, 1);
    check(rom_sel == 1'b0, "R8", "top read after boot", rom_sel, 0);
    // fast phase, with repeated trigger accesses
    for (int i = 0; i < 40; i++) step((i % 5 == 0) ? TRIG : pat(i + 100), (i % 2) == 0);
    step(16'hFFFE, 1'b1);
    check(rom_sel == 1'b0, "R9", "trigger does not restore boot", rom_sel, 0);
    // second run: reset brings boot back, copy loop, end boot by a write
    do_reset();
    step(16'hF900, 1'b1);
    check(rom_sel == 1'b1, "R9", "reset restores boot", rom_sel, 1);
    for (int k = 0; k < 6; k++) begin
      step(16'hF800 + k, 1'b1);
      step(16'hF800 + k, 1'b0);
    end
    while (m_boot) step(TRIG, 1'b0);
    check(last_ce_obs == 1'b1, "R6", "write trigger ends boot", last_ce_obs, 1);
    for (int i = 0; i < 10; i++) step(16'hF800 + i * 64, 1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule